// File: doc/BRIEF.md
# One-Wire Bus Reset and Presence Detector

This block runs the reset handshake on a single open-drain one-wire line. A start request makes it pull the line low for a fixed reset window. It then lets the line float high through the external pull-up. At one fixed point after the release it samples the line. A slave that is present drives the line low around that point, and the block records this as presence. The block then keeps the line released for the rest of a full recovery window. At the end it raises a one-cycle completion strobe, and the presence flag is valid in that same cycle.

All delays are counted in microsecond ticks. A divider inside the block makes these ticks from the system clock. The divider restarts on every accepted start, so each phase lasts an exact number of clocks. The line input passes through a two-flop synchronizer before it is sampled. The busy output is high for the whole sequence, so an arbiter can keep other bus users off the line. While busy, the block ignores further start requests.

Top module: `owrst_top`

## Requirements
- R1: While `rst` is high, `line_oe`, `busy`, `done` and `presence` are all 0, so the bus is never pulled low at power-up.
- R2: A `start` sampled high at a clock edge while `busy` is 0 makes `line_oe` and `busy` both 1 after that edge.
- R3: `line_oe` stays 1 for exactly `LOW_US*CLK_PER_US` clock cycles, then returns to 0.
- R4: After the low phase, `line_oe` stays 0 until the sequence ends. `line_oe` is never 1 while `busy` is 0.
- R5: The line is sampled once, `SAMPLE_US*CLK_PER_US` cycles after `line_oe` falls, through two synchronizer flops. The sample therefore reflects `line_in` as it was two clocks before that edge. A low level gives `presence` = 1.
- R6: A high level at that sample point gives `presence` = 0. This covers no slave, a slave that answers too late, and a slave whose pulse ends before the sample point.
- R7: `done` is a one-cycle pulse. It rises `REL_US*CLK_PER_US` cycles after `line_oe` falls, in the same cycle that `busy` falls. `busy` is high for exactly `(LOW_US+REL_US)*CLK_PER_US` cycles.
- R8: A `start` that arrives while `busy` is 1 has no effect on the phase lengths or on the result.
- R9: `presence` holds its value from the sample point until the next sample, including all the time the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a reset sequence (accepted only while idle) |
| line_in | input | 1 | Level read back from the one-wire line (asynchronous) |
| line_oe | output | 1 | Enable for the pull-low driver; 1 pulls the line low |
| busy | output | 1 | High for the whole sequence |
| done | output | 1 | One-cycle completion strobe |
| presence | output | 1 | 1 when a slave answered at the sample point |

## Verification
Each result has a fixed due cycle. `line_oe` and `busy` are due on the edge that accepts `start`. The low phase lasts LOW_US*CLK_PER_US clocks. The presence sample is due SAMPLE_US*CLK_PER_US clocks after release and reflects the line two clocks earlier. `done` is due REL_US*CLK_PER_US clocks after release. The bench samples on the falling clock edge and counts, in busy and low-phase cycles, the exact window lengths for each expected item. The slave model places its pulse edges one clock on either side of the synchronized sample point, so an off-by-one in the sample timing or in the synchronizer depth flips the expected presence.

// File: rtl/owrst_pkg.sv
package owrst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_REL  = 2'd2
  } owrst_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/owrst_tick.sv
module owrst_tick #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int unsigned W = owrst_pkg::cnt_width(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/owrst_sync.sv
module owrst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/owrst_seq.sv
module owrst_seq #(
  parameter int unsigned LOW_US    = 480,
  parameter int unsigned SAMPLE_US = 64,
  parameter int unsigned REL_US    = 480
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  input  logic line_s,
  output logic restart,
  output logic drive_low,
  output logic busy,
  output logic done,
  output logic presence
);
  import owrst_pkg::*;

  localparam int unsigned MAXUS = (LOW_US > REL_US) ? LOW_US : REL_US;
  localparam int unsigned UW    = cnt_width(MAXUS);
  localparam logic [UW-1:0] LOW_LAST = UW'(LOW_US - 1);
  localparam logic [UW-1:0] SMP_LAST = UW'(SAMPLE_US - 1);
  localparam logic [UW-1:0] REL_LAST = UW'(REL_US - 1);

  owrst_state_e state;
  logic [UW-1:0] us_cnt;

  assign restart = start && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      us_cnt    <= '0;
      drive_low <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      presence  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_LOW;
            drive_low <= 1'b1;
            busy      <= 1'b1;
            us_cnt    <= '0;
          end
        end
        ST_LOW: begin
          if (tick) begin
            if (us_cnt == LOW_LAST) begin
              state     <= ST_REL;
              drive_low <= 1'b0;
              us_cnt    <= '0;
            end else begin
              us_cnt <= us_cnt + 1'b1;
            end
          end
        end
        ST_REL: begin
          if (tick) begin
            if (us_cnt == SMP_LAST) presence <= ~line_s;
            if (us_cnt == REL_LAST) begin
              state  <= ST_IDLE;
              busy   <= 1'b0;
              done   <= 1'b1;
              us_cnt <= '0;
            end else begin
              us_cnt <= us_cnt + 1'b1;
            end
          end
        end
        default: begin
          state     <= ST_IDLE;
          drive_low <= 1'b0;
          busy      <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/owrst_top.sv
module owrst_top #(
  parameter int unsigned CLK_PER_US  = 50,
  parameter int unsigned LOW_US      = 480,
  parameter int unsigned SAMPLE_US   = 64,
  parameter int unsigned REL_US      = 480,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic line_in,
  output logic line_oe,
  output logic busy,
  output logic done,
  output logic presence
);
  logic tick;
  logic restart;
  logic line_s;

  owrst_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (tick)
  );

  owrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_in),
    .q   (line_s)
  );

  owrst_seq #(
    .LOW_US    (LOW_US),
    .SAMPLE_US (SAMPLE_US),
    .REL_US    (REL_US)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .tick      (tick),
    .line_s    (line_s),
    .restart   (restart),
    .drive_low (line_oe),
    .busy      (busy),
    .done      (done),
    .presence  (presence)
  );
endmodule

// File: rtl/owrst_chk.sv
module owrst_chk #(
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned LOW_US     = 480
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic line_oe,
  input logic busy,
  input logic done,
  input logic presence
);
  localparam int unsigned LOW_CYC = CLK_PER_US * LOW_US;

  int unsigned low_cnt;

  always_ff @(posedge clk) begin
    if (rst || !line_oe) low_cnt <= 0;
    else                 low_cnt <= low_cnt + 1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!line_oe && !busy && !done && !presence));

  p_start_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (line_oe && busy));

  p_low_max_r3: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> (low_cnt < LOW_CYC));

  p_low_exact_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(line_oe) |-> (low_cnt == LOW_CYC));

  p_oe_inside_busy_r4: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> busy);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy) && !line_oe));

  p_presence_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(presence));
endmodule

bind owrst_top owrst_chk #(
  .CLK_PER_US (CLK_PER_US),
  .LOW_US     (LOW_US)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .line_oe  (line_oe),
  .busy     (busy),
  .done     (done),
  .presence (presence)
);

// File: tb/owrst_top_tb.sv
module owrst_top_tb;
  localparam int unsigned NCLK     = 4;
  localparam int unsigned LOW_US   = 480;
  localparam int unsigned SMP_US   = 64;
  localparam int unsigned REL_US   = 480;
  localparam int          LOW_CYC  = NCLK * LOW_US;
  localparam int          BUSY_CYC = NCLK * (LOW_US + REL_US);
  localparam int          SMP_PT   = NCLK * SMP_US - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic line_in;
  logic line_oe, busy, done, presence;

  logic slave_low = 1'b0;
  bit   slave_en = 1'b0;
  int   slave_a = 0;
  int   slave_b = 0;
  int   rel_cnt = 0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit exp_q[$];
  int busy_cnt = 0;
  int oe_cnt = 0;
  bit prev_done = 1'b0;

  always #10 clk = ~clk;

  assign line_in = !(line_oe || slave_low);

  owrst_top #(
    .CLK_PER_US (NCLK),
    .LOW_US     (LOW_US),
    .SAMPLE_US  (SMP_US),
    .REL_US     (REL_US)
  ) u_dut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .line_in  (line_in),
    .line_oe  (line_oe),
    .busy     (busy),
    .done     (done),
    .presence (presence)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model: cycles counted from release
  always @(negedge clk) begin
    if (line_oe) rel_cnt <= 0;
    else if (rel_cnt < 100000) rel_cnt <= rel_cnt + 1;
    slave_low <= slave_en && !line_oe && (rel_cnt + 1 >= slave_a) && (rel_cnt + 1 < slave_b);
  end

  // monitor: compare each completion with the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done && done) check("R7 done width", 2, 1);
      prev_done <= done;
      if (busy) busy_cnt <= busy_cnt + 1;
      if (line_oe) oe_cnt <= oe_cnt + 1;
      if (line_oe && !busy) check("R4 oe outside busy", 1, 0);
      if (done) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected done", 1, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          check("R5/R6 presence", int'(presence), int'(e));
          check("R7 busy cycles", busy_cnt, BUSY_CYC);
          check("R3 low cycles", oe_cnt, LOW_CYC);
        end
        busy_cnt <= 0;
        oe_cnt <= 0;
      end
    end
  end

  task automatic run(input bit en, input int a, input int b, input bit extra_start);
    bit e;
    while (busy) @(negedge clk);
    slave_en = en;
    slave_a = a;
    slave_b = b;
    e = en && (SMP_PT >= a) && (SMP_PT < b);
    exp_q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 oe after start", int'(line_oe), 1);
    check("R2 busy after start", int'(busy), 1);
    if (extra_start) begin
      // R8: requests during the sequence must not disturb it
      repeat (100) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (LOW_CYC) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (12) @(negedge clk);
    check("R9 presence held", int'(presence), int'(e));
    check("R8 idle after run", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 oe in reset", int'(line_oe), 0);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 presence in reset", int'(presence), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    run(1'b1, 60, 540, 1'b0);              // R5 typical slave
    run(1'b0, 0, 0, 1'b0);                 // R6 no slave
    run(1'b1, 280, 600, 1'b0);             // R6 late slave
    run(1'b1, 60, 200, 1'b0);              // R6 pulse ends early
    run(1'b1, SMP_PT, 600, 1'b1);          // R5 edge: low exactly at sample, R8
    run(1'b1, SMP_PT + 1, 600, 1'b0);      // R6 edge: one clock late
    run(1'b1, 60, SMP_PT, 1'b0);           // R6 edge: ended one clock early
    run(1'b1, 60, SMP_PT + 1, 1'b1);       // R5 edge: ends just after, R8
    check("R7 scoreboard empty", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    check("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule